// File: doc/BRIEF.md
# Tape Command Header Validator

This block screens the header word of a magnetic-tape command before anything runs. A packet fetcher hands it the 16-bit header, the upper buffer-address word and a snapshot of the drive's state. The drive state covers whether a tape is online, whether it is write locked, whether it sits at the beginning of tape, whether volume check is raised, whether a buffer address is still needed, and whether an enabled attention is queued. One cycle later the block gives exactly one verdict. It either dispatches the function and mode to the executor, or rejects the command with a termination class, a set of status flags and the header code for the end message. A header without its acknowledge bit only produces a ready indication.

The checks run in a fixed priority order. Each function code has a legal-mode count and attributes: whether it moves the tape, whether it writes, and whether it uses a memory buffer. The first check that fails decides the rejection. When the header asks for volume check to be cleared, the block raises a one-cycle clear request. The cleared state then counts for the motion check of the same header.

Top module: `tape_cmd_validator`

## Requirements
- R1: A header with bit 15 (acknowledge) clear yields only a one-cycle `ready_o` pulse, with `irq_o` equal to header bit 7 (interrupt enable) and no dispatch, reject or clear request.
- R2: When `need_buf_i` is set and the function (bits 4:0) is not 4 (set characteristics), the command is rejected with class 3, no flags and message code 0x0000; function 4 is let through this check.
- R3: When `attn_i` is set and R2 does not apply, the command is rejected with class 1, no flags, message code 0x0013 and `irq_o` set regardless of bit 7.
- R4: Once R2 and R3 are passed, header bit 14 set pulses `vc_clear_o`, and the motion check of that same header treats volume check as clear.
- R5: Nonzero bits 6:5, or a mode (bits 11:8) not below the function's legal-mode count, rejects with class 3, flag bit 1 (illegal command) and code 0x8111. The counts are 4 for function 1, 1 for 4, 2 for 5, 1 for 6, 5 for 8, 3 for 9, 5 for 10, 1 for 11, 1 for 15 and 0 for every other code.
- R6: A motion function (1, 5, 8, 9, 10) with volume check in effect or `online_i` low is rejected with class 3, flag bit 2 (not executable) and code 0x8211.
- R7: A writing function (5, 9) on a write-locked tape is rejected with class 3, flag bits 3 (write lock) and 2 together, and code 0x8211.
- R8: Function 1 in mode 1, or function 8 in any odd mode, at beginning of tape is rejected with class 3, flag bit 2 and code 0x8211.
- R9: A buffer-using function (1, 5, 6) whose upper address word exceeds 0x003F is rejected with class 3, flag bit 0 (illegal address) and code 0x8111.
- R10: A header that passes every check pulses `dispatch_o` with the function, the mode, and header bits 13 and 12 on the dispatch outputs. On that cycle the class, flags and code are zero and `irq_o` is low.
- R11: The checks apply in the order R2, R3, R5, R6, R7, R8, R9, and only the first failing one decides the result.
- R12: Outputs are registered. Each header strobe gives, in the next cycle, exactly one of `dispatch_o`, `reject_o` or `ready_o` for one cycle. Without a strobe, and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid_i | input | 1 | Header strobe, one cycle per command |
| hdr_i | input | 16 | Command header word |
| addr_hi_i | input | 16 | Upper buffer-address word |
| online_i | input | 1 | Tape online |
| wlock_i | input | 1 | Tape write locked |
| bot_i | input | 1 | Tape at beginning of tape |
| volchk_i | input | 1 | Volume check raised |
| need_buf_i | input | 1 | Message buffer address not yet set |
| attn_i | input | 1 | Enabled attention pending |
| dispatch_o | output | 1 | Command accepted |
| func_o | output | 5 | Dispatched function |
| mode_o | output | 4 | Dispatched mode |
| opp_o | output | 1 | Dispatched opposite bit |
| swap_o | output | 1 | Dispatched byte-swap bit |
| reject_o | output | 1 | Command refused |
| tclass_o | output | 3 | Termination class on reject |
| flags_o | output | 4 | Reject flags: 0 illegal address, 1 illegal command, 2 not executable, 3 write lock |
| msg_o | output | 16 | End message header code on reject |
| ready_o | output | 1 | Ready without command (acknowledge clear) |
| irq_o | output | 1 | Interrupt request with the verdict |
| vc_clear_o | output | 1 | Clear volume check request |

## Verification
A wrong entry in the mode-count or attribute lookup would show at the ports on the very next cycle: a legal command would be refused with the illegal-command code, or a motion or write command would slip past the offline or lock test. A broken priority chain shows as the wrong flag set when two faults are present at once, so several vectors combine faults on purpose. A stuck output register shows as a pulse lasting more than one cycle, or as two verdicts at once. The back-to-back and idle-cycle checks expose that within a cycle.

// File: rtl/tcv_pkg.sv
// Package: shared field positions, function codes, message codes and the
// per-function attribute lookup used by the tape command header validator.
package tcv_pkg;

    localparam int HDR_W  = 16;
    localparam int FUNC_W = 5;
    localparam int MODE_W = 4;
    localparam int FLAG_W = 4;
    localparam int TC_W   = 3;
    localparam int LIM_W  = MODE_W + 1;

    // header bit positions
    localparam int B_ACK  = 15;
    localparam int B_CVC  = 14;
    localparam int B_OPP  = 13;
    localparam int B_SWP  = 12;
    localparam int B_IE   = 7;

    // function codes
    localparam logic [FUNC_W-1:0] F_READ = 5'd1;
    localparam logic [FUNC_W-1:0] F_CHAR = 5'd4;
    localparam logic [FUNC_W-1:0] F_WRT  = 5'd5;
    localparam logic [FUNC_W-1:0] F_MEMW = 5'd6;
    localparam logic [FUNC_W-1:0] F_POS  = 5'd8;
    localparam logic [FUNC_W-1:0] F_FMT  = 5'd9;
    localparam logic [FUNC_W-1:0] F_CTL  = 5'd10;
    localparam logic [FUNC_W-1:0] F_INIT = 5'd11;
    localparam logic [FUNC_W-1:0] F_STAT = 5'd15;

    // reject flag bit positions
    localparam int FL_ADDR = 0;
    localparam int FL_CMD  = 1;
    localparam int FL_NEX  = 2;
    localparam int FL_LOCK = 3;

    // message header codes
    localparam logic [HDR_W-1:0] MSG_ILLEGAL = 16'h8111;
    localparam logic [HDR_W-1:0] MSG_NOEXEC  = 16'h8211;
    localparam logic [HDR_W-1:0] MSG_ATTN    = 16'h0013;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_DISP  = 2'd1,
        V_REJ   = 2'd2,
        V_READY = 2'd3
    } vkind_t;

    typedef struct packed {
        logic [LIM_W-1:0] mode_lim;
        logic             moves;
        logic             writes;
        logic             uses_buf;
    } fattr_t;

    typedef struct packed {
        vkind_t             kind;
        logic [TC_W-1:0]    tclass;
        logic [FLAG_W-1:0]  flags;
        logic [HDR_W-1:0]   msg;
        logic               irq;
        logic               vc_clear;
    } verdict_t;

    // Legal-mode count and attributes for one function code.
    function automatic fattr_t func_attr(input logic [FUNC_W-1:0] f);
        fattr_t a;
        a = '0;
        unique case (f)
            F_READ:  a = '{mode_lim: 5'd4, moves: 1'b1, writes: 1'b0, uses_buf: 1'b1};
            F_CHAR:  a = '{mode_lim: 5'd1, moves: 1'b0, writes: 1'b0, uses_buf: 1'b0};
            F_WRT:   a = '{mode_lim: 5'd2, moves: 1'b1, writes: 1'b1, uses_buf: 1'b1};
            F_MEMW:  a = '{mode_lim: 5'd1, moves: 1'b0, writes: 1'b0, uses_buf: 1'b1};
            F_POS:   a = '{mode_lim: 5'd5, moves: 1'b1, writes: 1'b0, uses_buf: 1'b0};
            F_FMT:   a = '{mode_lim: 5'd3, moves: 1'b1, writes: 1'b1, uses_buf: 1'b0};
            F_CTL:   a = '{mode_lim: 5'd5, moves: 1'b1, writes: 1'b0, uses_buf: 1'b0};
            F_INIT:  a = '{mode_lim: 5'd1, moves: 1'b0, writes: 1'b0, uses_buf: 1'b0};
            F_STAT:  a = '{mode_lim: 5'd1, moves: 1'b0, writes: 1'b0, uses_buf: 1'b0};
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tcv_decode.sv
// Header decoder: splits the header into fields and looks up the function's
// legal-mode count and attributes. Purely combinational; assumes the header
// is stable while it is being judged.
module tcv_decode
    import tcv_pkg::*;
(
    input  logic [HDR_W-1:0]  hdr,
    output logic              ack,
    output logic              cvc,
    output logic              opp,
    output logic              swp,
    output logic              ie,
    output logic              mbz_bad,
    output logic [MODE_W-1:0] mode,
    output logic [FUNC_W-1:0] func,
    output logic              mode_bad,
    output logic              reverse,
    output fattr_t            attr
);

    // Field extraction and table lookup.
    always_comb begin
        ack      = hdr[B_ACK];
        cvc      = hdr[B_CVC];
        opp      = hdr[B_OPP];
        swp      = hdr[B_SWP];
        ie       = hdr[B_IE];
        mbz_bad  = |hdr[6:5];
        mode     = hdr[8 +: MODE_W];
        func     = hdr[0 +: FUNC_W];
        attr     = func_attr(func);
        mode_bad = ({1'b0, mode} >= attr.mode_lim);
        reverse  = ((func == F_READ) && (mode == 4'd1)) ||
                   ((func == F_POS)  && mode[0]);
    end

endmodule

// File: rtl/tcv_check_chain.sv
// Priority check chain: applies the screening tests in their fixed order and
// forms one verdict. Assumes decoded fields and drive state are valid in the
// same cycle; the result is only meaningful when a header is strobed.
module tcv_check_chain
    import tcv_pkg::*;
#(
    parameter logic [HDR_W-1:0] ADDR_LIMIT = 16'h003F
)(
    input  logic              ack,
    input  logic              cvc,
    input  logic              ie,
    input  logic              mbz_bad,
    input  logic              mode_bad,
    input  logic              reverse,
    input  logic [FUNC_W-1:0] func,
    input  fattr_t            attr,
    input  logic [HDR_W-1:0]  addr_hi,
    input  logic              online,
    input  logic              wlock,
    input  logic              bot,
    input  logic              volchk,
    input  logic              need_buf,
    input  logic              attn,
    output verdict_t          verdict
);

    logic vc_eff;

    // Volume check as seen by the motion test after an optional clear.
    always_comb vc_eff = volchk && !cvc;

    // First failing check decides the verdict.
    always_comb begin
        verdict = '0;
        if (!ack) begin
            verdict.kind = V_READY;
            verdict.irq  = ie;
        end else if (need_buf && (func != F_CHAR)) begin
            verdict.kind   = V_REJ;
            verdict.tclass = 3'd3;
            verdict.irq    = ie;
        end else if (attn) begin
            verdict.kind   = V_REJ;
            verdict.tclass = 3'd1;
            verdict.msg    = MSG_ATTN;
            verdict.irq    = 1'b1;
        end else begin
            verdict.vc_clear = cvc;
            verdict.kind     = V_REJ;
            verdict.tclass   = 3'd3;
            verdict.irq      = ie;
            if (mbz_bad || mode_bad) begin
                verdict.flags[FL_CMD] = 1'b1;
                verdict.msg           = MSG_ILLEGAL;
            end else if (attr.moves && (vc_eff || !online)) begin
                verdict.flags[FL_NEX] = 1'b1;
                verdict.msg           = MSG_NOEXEC;
            end else if (attr.writes && wlock) begin
                verdict.flags[FL_NEX]  = 1'b1;
                verdict.flags[FL_LOCK] = 1'b1;
                verdict.msg            = MSG_NOEXEC;
            end else if (reverse && bot) begin
                verdict.flags[FL_NEX] = 1'b1;
                verdict.msg           = MSG_NOEXEC;
            end else if (attr.uses_buf && (addr_hi > ADDR_LIMIT)) begin
                verdict.flags[FL_ADDR] = 1'b1;
                verdict.msg            = MSG_ILLEGAL;
            end else begin
                verdict.kind   = V_DISP;
                verdict.tclass = '0;
                verdict.irq    = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tcv_out_reg.sv
// Output stage: captures the verdict and dispatch fields for one cycle per
// header strobe and returns to all-zero otherwise. Synchronous active-low
// reset.
module tcv_out_reg
    import tcv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  verdict_t          verdict,
    input  logic [FUNC_W-1:0] func,
    input  logic [MODE_W-1:0] mode,
    input  logic              opp,
    input  logic              swp,
    output logic              dispatch_o,
    output logic [FUNC_W-1:0] func_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              opp_o,
    output logic              swap_o,
    output logic              reject_o,
    output logic [TC_W-1:0]   tclass_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [HDR_W-1:0]  msg_o,
    output logic              ready_o,
    output logic              irq_o,
    output logic              vc_clear_o
);

    logic take, is_disp;

    // Qualify the verdict with the strobe.
    always_comb begin
        take    = strobe && (verdict.kind != V_NONE);
        is_disp = take && (verdict.kind == V_DISP);
    end

    // Register one-cycle verdict pulses and their payload.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            dispatch_o <= 1'b0;
            func_o     <= '0;
            mode_o     <= '0;
            opp_o      <= 1'b0;
            swap_o     <= 1'b0;
            reject_o   <= 1'b0;
            tclass_o   <= '0;
            flags_o    <= '0;
            msg_o      <= '0;
            ready_o    <= 1'b0;
            irq_o      <= 1'b0;
            vc_clear_o <= 1'b0;
        end else begin
            dispatch_o <= is_disp;
            func_o     <= is_disp ? func : '0;
            mode_o     <= is_disp ? mode : '0;
            opp_o      <= is_disp && opp;
            swap_o     <= is_disp && swp;
            reject_o   <= (verdict.kind == V_REJ);
            tclass_o   <= verdict.tclass;
            flags_o    <= verdict.flags;
            msg_o      <= verdict.msg;
            ready_o    <= (verdict.kind == V_READY);
            irq_o      <= verdict.irq;
            vc_clear_o <= verdict.vc_clear;
        end
    end

endmodule

// File: rtl/tape_cmd_validator.sv
// Top: screens one tape command header per strobe against the drive state
// and answers one cycle later with dispatch, reject or ready. Assumes all
// inputs are synchronous to clk and valid together with hdr_valid_i.
module tape_cmd_validator
    import tcv_pkg::*;
#(
    parameter logic [15:0] ADDR_LIMIT = 16'h003F
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid_i,
    input  logic [15:0] hdr_i,
    input  logic [15:0] addr_hi_i,
    input  logic        online_i,
    input  logic        wlock_i,
    input  logic        bot_i,
    input  logic        volchk_i,
    input  logic        need_buf_i,
    input  logic        attn_i,
    output logic        dispatch_o,
    output logic [4:0]  func_o,
    output logic [3:0]  mode_o,
    output logic        opp_o,
    output logic        swap_o,
    output logic        reject_o,
    output logic [2:0]  tclass_o,
    output logic [3:0]  flags_o,
    output logic [15:0] msg_o,
    output logic        ready_o,
    output logic        irq_o,
    output logic        vc_clear_o
);

    logic              ack, cvc, opp, swp, ie, mbz_bad, mode_bad, reverse;
    logic [MODE_W-1:0] mode;
    logic [FUNC_W-1:0] func;
    fattr_t            attr;
    verdict_t          verdict;

    tcv_decode u_decode (
        .hdr      (hdr_i),
        .ack      (ack),
        .cvc      (cvc),
        .opp      (opp),
        .swp      (swp),
        .ie       (ie),
        .mbz_bad  (mbz_bad),
        .mode     (mode),
        .func     (func),
        .mode_bad (mode_bad),
        .reverse  (reverse),
        .attr     (attr)
    );

    tcv_check_chain #(.ADDR_LIMIT(ADDR_LIMIT)) u_chain (
        .ack      (ack),
        .cvc      (cvc),
        .ie       (ie),
        .mbz_bad  (mbz_bad),
        .mode_bad (mode_bad),
        .reverse  (reverse),
        .func     (func),
        .attr     (attr),
        .addr_hi  (addr_hi_i),
        .online   (online_i),
        .wlock    (wlock_i),
        .bot      (bot_i),
        .volchk   (volchk_i),
        .need_buf (need_buf_i),
        .attn     (attn_i),
        .verdict  (verdict)
    );

    tcv_out_reg u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (hdr_valid_i),
        .verdict    (verdict),
        .func       (func),
        .mode       (mode),
        .opp        (opp),
        .swp        (swp),
        .dispatch_o (dispatch_o),
        .func_o     (func_o),
        .mode_o     (mode_o),
        .opp_o      (opp_o),
        .swap_o     (swap_o),
        .reject_o   (reject_o),
        .tclass_o   (tclass_o),
        .flags_o    (flags_o),
        .msg_o      (msg_o),
        .ready_o    (ready_o),
        .irq_o      (irq_o),
        .vc_clear_o (vc_clear_o)
    );

endmodule

// File: rtl/tape_cmd_validator_chk.sv
// Checker: temporal properties of the validator's ports, bound to the top.
module tape_cmd_validator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hdr_valid_i,
    input logic [15:0] hdr_i,
    input logic [15:0] addr_hi_i,
    input logic        dispatch_o,
    input logic [4:0]  func_o,
    input logic        reject_o,
    input logic [2:0]  tclass_o,
    input logic [3:0]  flags_o,
    input logic [15:0] msg_o,
    input logic        ready_o,
    input logic        irq_o,
    input logic        vc_clear_o
);

    assert_one_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dispatch_o, reject_o, ready_o}));

    assert_verdict_needs_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_i |=> ($countones({dispatch_o, reject_o, ready_o}) == 1));

    assert_no_strobe_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid_i |=> !(dispatch_o || reject_o || ready_o || vc_clear_o));

    assert_ready_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && !hdr_i[15]) |=> (ready_o && (irq_o == $past(hdr_i[7]))));

    assert_vc_clear_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_i && !(hdr_i[15] && hdr_i[14]) |=> !vc_clear_o);

    assert_attn_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && tclass_o == 3'd1) |-> (irq_o && msg_o == 16'h0013));

    assert_addr_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && flags_o[0]) |-> (msg_o == 16'h8111 && tclass_o == 3'd3));

    assert_dispatch_func_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_i |=> (!dispatch_o || (func_o == $past(hdr_i[4:0]) && msg_o == 16'h0 && !irq_o)));

    assert_addr_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid_i && addr_hi_i <= 16'h003F) |=> !(reject_o && flags_o[0]));

endmodule

bind tape_cmd_validator tape_cmd_validator_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid_i (hdr_valid_i),
    .hdr_i       (hdr_i),
    .addr_hi_i   (addr_hi_i),
    .dispatch_o  (dispatch_o),
    .func_o      (func_o),
    .reject_o    (reject_o),
    .tclass_o    (tclass_o),
    .flags_o     (flags_o),
    .msg_o       (msg_o),
    .ready_o     (ready_o),
    .irq_o       (irq_o),
    .vc_clear_o  (vc_clear_o)
);

// File: tb/tape_cmd_validator_test.sv
module tape_cmd_validator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid_i = 1'b0;
    logic [15:0] hdr_i = '0;
    logic [15:0] addr_hi_i = '0;
    logic        online_i = 1'b0, wlock_i = 1'b0, bot_i = 1'b0;
    logic        volchk_i = 1'b0, need_buf_i = 1'b0, attn_i = 1'b0;
    logic        dispatch_o, opp_o, swap_o, reject_o, ready_o, irq_o, vc_clear_o;
    logic [4:0]  func_o;
    logic [3:0]  mode_o;
    logic [2:0]  tclass_o;
    logic [3:0]  flags_o;
    logic [15:0] msg_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tape_cmd_validator uut (
        .clk(clk), .rst_n(rst_n), .hdr_valid_i(hdr_valid_i), .hdr_i(hdr_i),
        .addr_hi_i(addr_hi_i), .online_i(online_i), .wlock_i(wlock_i),
        .bot_i(bot_i), .volchk_i(volchk_i), .need_buf_i(need_buf_i),
        .attn_i(attn_i), .dispatch_o(dispatch_o), .func_o(func_o),
        .mode_o(mode_o), .opp_o(opp_o), .swap_o(swap_o), .reject_o(reject_o),
        .tclass_o(tclass_o), .flags_o(flags_o), .msg_o(msg_o),
        .ready_o(ready_o), .irq_o(irq_o), .vc_clear_o(vc_clear_o)
    );

    // kind: 0 none, 1 dispatch, 2 reject, 3 ready
    // cond: {online, wlock, bot, volchk, need_buf, attn}
    typedef struct packed {
        logic [15:0] hdr;
        logic [15:0] ahi;
        logic [5:0]  cond;
        logic [1:0]  kind;
        logic [2:0]  tc;
        logic [3:0]  flg;
        logic [15:0] msg;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{16'h8001, 16'h0000, 6'b100000, 2'd1, 3'd0, 4'h0, 16'h0000}, // R10 read
        '{16'h8408, 16'h0000, 6'b100000, 2'd1, 3'd0, 4'h0, 16'h0000}, // R10 rewind
        '{16'h8401, 16'h0000, 6'b100000, 2'd2, 3'd3, 4'h2, 16'h8111}, // R5 mode
        '{16'h8021, 16'h0000, 6'b100000, 2'd2, 3'd3, 4'h2, 16'h8111}, // R5 mbz
        '{16'h8002, 16'h0000, 6'b100000, 2'd2, 3'd3, 4'h2, 16'h8111}, // R5 code
        '{16'h8005, 16'h0000, 6'b000000, 2'd2, 3'd3, 4'h4, 16'h8211}, // R6 offline
        '{16'h8005, 16'h0000, 6'b110000, 2'd2, 3'd3, 4'hC, 16'h8211}, // R7 write
        '{16'h8101, 16'h0000, 6'b101000, 2'd2, 3'd3, 4'h4, 16'h8211}, // R8 read rev
        '{16'h8308, 16'h0000, 6'b101000, 2'd2, 3'd3, 4'h4, 16'h8211}, // R8 pos odd
        '{16'h8208, 16'h0000, 6'b101000, 2'd1, 3'd0, 4'h0, 16'h0000}, // R8 pos even
        '{16'h8001, 16'h0040, 6'b100000, 2'd2, 3'd3, 4'h1, 16'h8111}, // R9 over
        '{16'h8001, 16'h003F, 6'b100000, 2'd1, 3'd0, 4'h0, 16'h0000}, // R9 edge
        '{16'h8006, 16'h0100, 6'b000000, 2'd2, 3'd3, 4'h1, 16'h8111}, // R9 memw
        '{16'h8001, 16'h0000, 6'b100010, 2'd2, 3'd3, 4'h0, 16'h0000}, // R2
        '{16'h8004, 16'h0000, 6'b100010, 2'd1, 3'd0, 4'h0, 16'h0000}, // R2 char
        '{16'h8001, 16'h0000, 6'b100001, 2'd2, 3'd1, 4'h0, 16'h0013}, // R3
        '{16'h8001, 16'h0000, 6'b100011, 2'd2, 3'd3, 4'h0, 16'h0000}, // R11 nba>attn
        '{16'h8001, 16'h0000, 6'b100100, 2'd2, 3'd3, 4'h4, 16'h8211}, // R6 volchk
        '{16'hC001, 16'h0000, 6'b100100, 2'd1, 3'd0, 4'h0, 16'h0000}, // R4 cleared
        '{16'h0005, 16'h0000, 6'b100000, 2'd3, 3'd0, 4'h0, 16'h0000}, // R1
        '{16'h8401, 16'h0000, 6'b000000, 2'd2, 3'd3, 4'h2, 16'h8111}, // R11 cmd>offline
        '{16'h8009, 16'h0000, 6'b110000, 2'd2, 3'd3, 4'hC, 16'h8211}, // R7 format
        '{16'h8005, 16'hFFC0, 6'b010000, 2'd2, 3'd3, 4'h4, 16'h8211}, // R11 offline first
        '{16'h850A, 16'h0000, 6'b100000, 2'd2, 3'd3, 4'h2, 16'h8111}, // R5 ctl mode 5
        '{16'h800F, 16'h0000, 6'b000000, 2'd1, 3'd0, 4'h0, 16'h0000}  // R10 status offline
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] h, input logic [15:0] a, input logic [5:0] c);
        hdr_valid_i = 1'b1;
        hdr_i = h;
        addr_hi_i = a;
        {online_i, wlock_i, bot_i, volchk_i, need_buf_i, attn_i} = c;
    endtask

    function automatic logic [1:0] kind_now();
        return dispatch_o ? 2'd1 : reject_o ? 2'd2 : ready_o ? 2'd3 : 2'd0;
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state R12
        check({dispatch_o, reject_o, ready_o, irq_o, vc_clear_o, msg_o, flags_o, tclass_o} == '0,
              "R12 reset", {27'd0, dispatch_o, reject_o, ready_o, irq_o, vc_clear_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic exp_vc, exp_irq;
            v = VECS[i];
            drive(v.hdr, v.ahi, v.cond);
            exp_vc = v.hdr[15] && v.hdr[14] && !(v.cond[1] && v.hdr[4:0] != 5'd4) && !v.cond[0];
            exp_irq = (v.kind == 2'd2 && v.tc == 3'd1);
            @(negedge clk);
            hdr_valid_i = 1'b0;
            check(kind_now() == v.kind, $sformatf("R11 vec%0d kind", i), kind_now(), v.kind);
            check(tclass_o == v.tc && flags_o == v.flg && msg_o == v.msg,
                  $sformatf("R5-R9 vec%0d class/flags/code", i),
                  {9'd0, tclass_o, flags_o, msg_o}, {9'd0, v.tc, v.flg, v.msg});
            check(vc_clear_o == exp_vc, $sformatf("R4 vec%0d clear", i), vc_clear_o, exp_vc);
            check(irq_o == exp_irq, $sformatf("R3 vec%0d irq", i), irq_o, exp_irq);
            if (v.kind == 2'd1)
                check(func_o == v.hdr[4:0] && mode_o == v.hdr[11:8],
                      $sformatf("R10 vec%0d fields", i), {func_o, mode_o}, {v.hdr[4:0], v.hdr[11:8]});
        end

        // R12: pulse lasts one cycle, nothing without a strobe
        @(negedge clk);
        check(kind_now() == 2'd0 && !vc_clear_o, "R12 idle", kind_now(), 0);

        // R1: ready with interrupt enable
        drive(16'h0080, 16'h0, 6'b100000);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(ready_o && irq_o && !vc_clear_o, "R1 ready irq", {ready_o, irq_o}, 2'b11);

        // R10: dispatch never interrupts, opposite/swap passed on
        drive(16'hB281, 16'h0, 6'b100000);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(dispatch_o && !irq_o && opp_o && swap_o && mode_o == 4'd2,
              "R10 opp swap", {dispatch_o, irq_o, opp_o, swap_o, mode_o}, 8'b1011_0010);

        // R5 reject with interrupt enable
        drive(16'h8481, 16'h0, 6'b100000);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(reject_o && irq_o, "R5 reject irq", {reject_o, irq_o}, 2'b11);

        // R3: attention interrupt even with IE set, no volume clear
        drive(16'hC081, 16'h0, 6'b100001);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(reject_o && irq_o && tclass_o == 3'd1 && !vc_clear_o,
              "R3 attn no clear", {reject_o, irq_o, vc_clear_o}, 3'b110);

        // R4: clear on a command rejected later still pulses
        drive(16'hC401, 16'h0, 6'b100100);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(vc_clear_o && reject_o && flags_o == 4'h2, "R4 clear with reject",
              {vc_clear_o, reject_o, flags_o}, 6'b11_0010);

        // R12: back-to-back strobes
        drive(16'h8001, 16'h0, 6'b100000);
        @(negedge clk);
        check(dispatch_o && !reject_o, "R12 b2b first", {dispatch_o, reject_o}, 2'b10);
        drive(16'h8002, 16'h0, 6'b100000);
        @(negedge clk); hdr_valid_i = 1'b0;
        check(reject_o && !dispatch_o && func_o == 5'd0, "R12 b2b second",
              {reject_o, dispatch_o, func_o}, 7'b10_00000);
        @(negedge clk);
        check(kind_now() == 2'd0, "R12 after b2b", kind_now(), 0);

        // R12: reset mid-stream clears outputs
        drive(16'h8001, 16'h0, 6'b100000);
        rst_n = 1'b0;
        @(negedge clk); hdr_valid_i = 1'b0;
        check(kind_now() == 2'd0, "R12 reset wins", kind_now(), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule